// File: doc/BRIEF.md
# PHY Power Sequencing Controller

This block is a hardware sequencer for a serial display PHY. It accepts two commands: one brings the PHY up and one takes it down. It then walks a fixed list of configuration-register updates over a simple request/acknowledge register bus. Each update touches only the bits named by a mask. The sequencer reads the register, merges the new bits under the mask and writes the result back, so every other bit keeps its value.

The two reset pulses and the final settle interval are timed with a microsecond prescaler derived from the system clock. Per-lane timing programming is delegated to an external timing engine through a start/done handshake. That handshake is issued once per enabled data lane, from the highest lane down to lane 0, and then once for the clock lane.

The lane count is sampled when a power-up starts. A power-down request that arrives during a power-up is remembered and runs as soon as the power-up ends. A power-up request that arrives while any sequence is running is dropped.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_rd`, `bus_wr` and `tim_start` are all low.
- R2: Power-up performs these updates in order:
  - lane-control (address 0x000): clear bit 7;
  - lane-control: bits 1:0 become 01;
  - power-control (0x004): clear bits 1:0;
  - lane-control: set the lane enables (see R3);
  - power-control: set bit 2, wait, then clear bit 2;
  - digital-control (0x080): clear bit 0, wait, then set bit 0;
  - run the timing handshakes;
  - wait again.
- R3: The lane-enable mask always holds bit 6 and bit 2. A lane count of 2 adds bit 3, a count of 3 adds bits 3 and 4, and a count of 4 adds bits 3 to 5. A count of 0, or any count above 4, is treated as 1.
- R4: Every update is a read of an address followed by a write to the same address. Bits outside the update mask are written back unchanged.
- R5: A strobe (`bus_rd` or `bus_wr`) stays high with a stable address until `bus_ack`. `bus_rd` and `bus_wr` are never high together.
- R6: The active-high analog reset (power-control bit 2) and the active-low digital reset (digital-control bit 0) are each held for at least HOLD_US microseconds, that is, HOLD_US*CLK_PER_US clock cycles.
- R7: `tim_start` is a one-cycle pulse per lane, and the next lane waits for `tim_done`. Lane codes are issued in the order N-1 down to 0 (data lanes), then 4 (the clock lane).
- R8: After the last `tim_done`, `done` is reported no earlier than HOLD_US microseconds later.
- R9: Power-down performs these updates in order:
  - lane-control: clear bits 6:2;
  - power-control: set bits 1:0;
  - lane-control: bits 1:0 become 10;
  - lane-control: set bit 7;
  - LVDS-control (0x3AC): set bit 0.
- R10: `busy` is high while a sequence runs. `done` pulses for exactly one cycle at the end of each sequence, with `busy` low in that cycle.
- R11: A power-down request during a power-up is held and runs after the power-up, giving two `done` pulses. A power-up request during any sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up_req | input | 1 | Start the power-up sequence |
| pwr_dn_req | input | 1 | Start (or queue) the power-down sequence |
| lane_cnt | input | 3 | Number of data lanes, 1 to 4 |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| bus_addr | output | 10 | Register address |
| bus_rd | output | 1 | Read strobe, held until acknowledge |
| bus_wr | output | 1 | Write strobe, held until acknowledge |
| bus_wdata | output | 8 | Write data (merged value) |
| bus_rdata | input | 8 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Access acknowledge |
| tim_start | output | 1 | Start timing programming for `tim_lane` |
| tim_lane | output | 3 | Lane code: 0 to 3 for data lanes, 4 for the clock lane |
| tim_done | input | 1 | Timing engine finished the current lane |

## Verification
The assertions check the bus rules on every cycle. These cover the mutual exclusion of the strobes, strobes and address held until acknowledge, and each write following a read. The assertions also check that `done` and `tim_start` are single-cycle pulses and that `done` never coincides with `busy`.

Only the scenarios can show the rest:
- the exact order and values of the register updates;
- the preservation of unmasked bits;
- the lane-count decoding, including the unsupported counts;
- the descending timing order;
- the reset hold and settle durations;
- the queuing of a power-down behind a power-up.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int LANE_W = 3;
    localparam int IDX_W  = 4;

    localparam logic [ADDR_W-1:0] A_LANE = 10'h000;
    localparam logic [ADDR_W-1:0] A_PWR  = 10'h004;
    localparam logic [ADDR_W-1:0] A_DIG  = 10'h080;
    localparam logic [ADDR_W-1:0] A_LVDS = 10'h3AC;

    localparam logic [LANE_W-1:0] CLK_LANE = 3'd4;

    typedef enum logic [1:0] {K_RMW, K_WAIT, K_TIM} kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] val;
        logic              last;
    } step_t;

    // Unsupported counts fall back to a single lane.
    function automatic logic [LANE_W-1:0] eff_lanes(input logic [LANE_W-1:0] n);
        return (n >= 3'd1 && n <= 3'd4) ? n : 3'd1;
    endfunction

    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANE_W-1:0] n);
        logic [DATA_W-1:0] m;
        m = 8'h44;
        if (n >= 3'd2) m = m | 8'h08;
        if (n >= 3'd3) m = m | 8'h10;
        if (n >= 3'd4) m = m | 8'h20;
        return m;
    endfunction

    function automatic step_t mk(input kind_e k, input logic [ADDR_W-1:0] a,
                                 input logic [DATA_W-1:0] m, input logic [DATA_W-1:0] v,
                                 input logic l);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.mask = m;
        s.val  = v;
        s.last = l;
        return s;
    endfunction

    function automatic step_t up_step(input logic [IDX_W-1:0] i, input logic [DATA_W-1:0] en);
        case (i)
            4'd0:    return mk(K_RMW,  A_LANE, 8'h80, 8'h00, 1'b0);
            4'd1:    return mk(K_RMW,  A_LANE, 8'h03, 8'h01, 1'b0);
            4'd2:    return mk(K_RMW,  A_PWR,  8'h03, 8'h00, 1'b0);
            4'd3:    return mk(K_RMW,  A_LANE, en,    en,    1'b0);
            4'd4:    return mk(K_RMW,  A_PWR,  8'h04, 8'h04, 1'b0);
            4'd5:    return mk(K_WAIT, A_LANE, 8'h00, 8'h00, 1'b0);
            4'd6:    return mk(K_RMW,  A_PWR,  8'h04, 8'h00, 1'b0);
            4'd7:    return mk(K_RMW,  A_DIG,  8'h01, 8'h00, 1'b0);
            4'd8:    return mk(K_WAIT, A_LANE, 8'h00, 8'h00, 1'b0);
            4'd9:    return mk(K_RMW,  A_DIG,  8'h01, 8'h01, 1'b0);
            4'd10:   return mk(K_TIM,  A_LANE, 8'h00, 8'h00, 1'b0);
            default: return mk(K_WAIT, A_LANE, 8'h00, 8'h00, 1'b1);
        endcase
    endfunction

    function automatic step_t dn_step(input logic [IDX_W-1:0] i);
        case (i)
            4'd0:    return mk(K_RMW, A_LANE, 8'h7C, 8'h00, 1'b0);
            4'd1:    return mk(K_RMW, A_PWR,  8'h03, 8'h03, 1'b0);
            4'd2:    return mk(K_RMW, A_LANE, 8'h03, 8'h02, 1'b0);
            4'd3:    return mk(K_RMW, A_LANE, 8'h80, 8'h80, 1'b0);
            default: return mk(K_RMW, A_LVDS, 8'h01, 8'h01, 1'b1);
        endcase
    endfunction
endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int CLK_PER_US = 50,
    parameter int HOLD_US    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int US_W  = (HOLD_US > 1) ? $clog2(HOLD_US) : 1;
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_US - 1);
    localparam logic [US_W-1:0]  US_MAX  = US_W'(HOLD_US - 1);

    typedef struct packed {
        logic             active;
        logic [PRE_W-1:0] pre;
        logic [US_W-1:0]  us;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.active = 1'b1;
            d.pre    = '0;
            d.us     = '0;
        end else if (q.active) begin
            if (q.pre == PRE_MAX) begin
                d.pre = '0;
                if (q.us == US_MAX) d.active = 1'b0;
                else                d.us = q.us + 1'b1;
            end else begin
                d.pre = q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expire = q.active && (q.pre == PRE_MAX) && (q.us == US_MAX);

    AST_TMR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !start |=> !expire); // R6
endmodule

// File: rtl/pps_rmw.sv
module pps_rmw
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] val,
    output logic              fin,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    typedef enum logic [1:0] {R_IDLE, R_RD, R_WR} rst_e;

    typedef struct packed {
        rst_e              st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] rd;
    } rmw_t;

    rmw_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            R_IDLE: if (start) begin
                d.st   = R_RD;
                d.addr = addr;
                d.mask = mask;
                d.val  = val;
            end
            R_RD: if (bus_ack) begin
                d.rd = bus_rdata;
                d.st = R_WR;
            end
            R_WR: if (bus_ack) d.st = R_IDLE;
            default: d.st = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_addr  = q.addr;
    assign bus_rd    = (q.st == R_RD);
    assign bus_wr    = (q.st == R_WR);
    assign bus_wdata = (q.rd & ~q.mask) | (q.val & q.mask);
    assign fin       = (q.st == R_WR) && bus_ack;

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R5
    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !bus_ack |=> bus_rd); // R5
    AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !bus_ack |=> bus_wr); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && !bus_ack |=> $stable(bus_addr)); // R5
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_rd) && $stable(bus_addr)); // R4
endmodule

// File: rtl/pps_seq.sv
module pps_seq
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up_req,
    input  logic              pwr_dn_req,
    input  logic [LANE_W-1:0] lane_cnt,
    output logic              busy,
    output logic              done,
    output logic              rmw_start,
    output logic [ADDR_W-1:0] rmw_addr,
    output logic [DATA_W-1:0] rmw_mask,
    output logic [DATA_W-1:0] rmw_val,
    input  logic              rmw_fin,
    output logic              tmr_start,
    input  logic              tmr_expire,
    output logic              tim_start,
    output logic [LANE_W-1:0] tim_lane,
    input  logic              tim_done
);
    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RMW, S_WAIT, S_TIM_GO, S_TIM_WAIT} st_e;

    typedef struct packed {
        st_e              st;
        logic [IDX_W-1:0] idx;
        logic             dn;
        logic [LANE_W-1:0] lanes;
        logic [LANE_W-1:0] lane;
        logic             pend;
        logic             busy;
        logic             done;
    } seq_t;

    seq_t  q, d;
    step_t cur;
    logic  step_end;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        rmw_start = 1'b0;
        tmr_start = 1'b0;
        step_end  = 1'b0;
        cur       = q.dn ? dn_step(q.idx) : up_step(q.idx, lane_bits(q.lanes));

        if (pwr_dn_req && q.busy && !q.dn) d.pend = 1'b1;

        case (q.st)
            S_IDLE: begin
                if (q.pend) begin
                    d.st   = S_FETCH;
                    d.dn   = 1'b1;
                    d.idx  = '0;
                    d.busy = 1'b1;
                    d.pend = 1'b0;
                end else if (pwr_up_req) begin
                    d.st    = S_FETCH;
                    d.dn    = 1'b0;
                    d.idx   = '0;
                    d.busy  = 1'b1;
                    d.lanes = eff_lanes(lane_cnt);
                    d.pend  = pwr_dn_req;
                end else if (pwr_dn_req) begin
                    d.st   = S_FETCH;
                    d.dn   = 1'b1;
                    d.idx  = '0;
                    d.busy = 1'b1;
                end
            end
            S_FETCH: begin
                case (cur.kind)
                    K_RMW: begin
                        rmw_start = 1'b1;
                        d.st      = S_RMW;
                    end
                    K_WAIT: begin
                        tmr_start = 1'b1;
                        d.st      = S_WAIT;
                    end
                    default: begin
                        d.lane = q.lanes - 3'd1;
                        d.st   = S_TIM_GO;
                    end
                endcase
            end
            S_RMW:    if (rmw_fin) step_end = 1'b1;
            S_WAIT:   if (tmr_expire) step_end = 1'b1;
            S_TIM_GO: d.st = S_TIM_WAIT;
            S_TIM_WAIT: begin
                if (tim_done) begin
                    if (q.lane == CLK_LANE) begin
                        step_end = 1'b1;
                    end else if (q.lane == '0) begin
                        d.lane = CLK_LANE;
                        d.st   = S_TIM_GO;
                    end else begin
                        d.lane = q.lane - 3'd1;
                        d.st   = S_TIM_GO;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (step_end) begin
            if (cur.last) begin
                d.st   = S_IDLE;
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.idx = q.idx + 1'b1;
                d.st  = S_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign done      = q.done;
    assign rmw_addr  = cur.addr;
    assign rmw_mask  = cur.mask;
    assign rmw_val   = cur.val;
    assign tim_start = (q.st == S_TIM_GO);
    assign tim_lane  = q.lane;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_TIM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tim_start |=> !tim_start); // R7
    AST_TIM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tim_start |-> busy && (tim_lane <= CLK_LANE)); // R7
    AST_BUSY_FALLS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R10
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import pps_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int HOLD_US    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up_req,
    input  logic              pwr_dn_req,
    input  logic [LANE_W-1:0] lane_cnt,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              tim_start,
    output logic [LANE_W-1:0] tim_lane,
    input  logic              tim_done
);
    logic              rmw_start, rmw_fin, tmr_start, tmr_expire;
    logic [ADDR_W-1:0] rmw_addr;
    logic [DATA_W-1:0] rmw_mask, rmw_val;

    pps_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req), .lane_cnt(lane_cnt),
        .busy(busy), .done(done),
        .rmw_start(rmw_start), .rmw_addr(rmw_addr), .rmw_mask(rmw_mask),
        .rmw_val(rmw_val), .rmw_fin(rmw_fin),
        .tmr_start(tmr_start), .tmr_expire(tmr_expire),
        .tim_start(tim_start), .tim_lane(tim_lane), .tim_done(tim_done)
    );

    pps_rmw u_rmw (
        .clk(clk), .rst_n(rst_n),
        .start(rmw_start), .addr(rmw_addr), .mask(rmw_mask), .val(rmw_val),
        .fin(rmw_fin),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    pps_timer #(.CLK_PER_US(CLK_PER_US), .HOLD_US(HOLD_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .expire(tmr_expire)
    );
endmodule

// File: tb/phy_pwr_seq_bench.sv
module phy_pwr_seq_bench;
    localparam int CPU  = 50;
    localparam int HOLD = 1;
    localparam int HOLD_CYC = CPU * HOLD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_up_req = 1'b0, pwr_dn_req = 1'b0;
    logic [2:0] lane_cnt = 3'd4;
    logic       busy, done, bus_rd, bus_wr, tim_start, tim_done = 1'b0;
    logic [9:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata = 8'h00;
    logic       bus_ack = 1'b0;
    logic [2:0] tim_lane;

    phy_pwr_seq #(.CLK_PER_US(CPU), .HOLD_US(HOLD)) u_phy_pwr_seq (
        .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req),
        .lane_cnt(lane_cnt), .busy(busy), .done(done), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .tim_start(tim_start), .tim_lane(tim_lane), .tim_done(tim_done)
    );

    always #10 clk = ~clk;

    int total = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] mem [0:3];
    logic [7:0] sh  [0:3];
    int acc_n = 0, exp_n = 0, tn = 0, done_cnt = 0;
    bit acc_wr [0:63];
    logic [9:0] acc_addr [0:63];
    logic [7:0] acc_data [0:63];
    int acc_cyc [0:63];
    logic [9:0] exp_addr [0:31];
    logic [7:0] exp_data [0:31];
    int tim_log [0:15];
    int tim_pend = 0, last_tim_cyc = 0, done_cyc = 0;
    int dly = 0, wait_n = 0, bus_viol = 0, bad_addr = 0, dup_done = 0;
    bit prev_strobe = 0, prev_ack = 0, done_prev = 0;

    function automatic int ridx(input logic [9:0] a);
        case (a)
            10'h000: return 0;
            10'h004: return 1;
            10'h080: return 2;
            10'h3AC: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Register bus responder with a varying acknowledge delay.
    always @(negedge clk) begin
        if (bus_rd && bus_wr) bus_viol++;
        if (prev_strobe && !prev_ack && !(bus_rd || bus_wr)) bus_viol++;
        prev_strobe = bus_rd || bus_wr;
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_rd || bus_wr) begin
            if (wait_n < dly) wait_n++;
            else begin
                int k;
                wait_n = 0;
                dly = (dly == 2) ? 0 : dly + 1;
                k = ridx(bus_addr);
                if (k < 0) bad_addr++;
                else if (acc_n < 64) begin
                    acc_wr[acc_n] = bus_wr;
                    acc_addr[acc_n] = bus_addr;
                    acc_cyc[acc_n] = cyc;
                    if (bus_wr) begin
                        mem[k] = bus_wdata;
                        acc_data[acc_n] = bus_wdata;
                    end else begin
                        bus_rdata = mem[k];
                        acc_data[acc_n] = mem[k];
                    end
                    acc_n++;
                end
                bus_ack = 1'b1;
            end
        end
        prev_ack = bus_ack;
    end

    // Timing engine model.
    always @(negedge clk) begin
        if (tim_done) tim_done = 1'b0;
        else if (tim_pend > 0) begin
            tim_pend--;
            if (tim_pend == 0) begin
                tim_done = 1'b1;
                last_tim_cyc = cyc;
            end
        end
        if (tim_start) begin
            if (tn < 16) tim_log[tn] = int'(tim_lane);
            tn++;
            tim_pend = 3;
        end
    end

    // Done pulse monitor.
    always @(negedge clk) begin
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
            if (done_prev) dup_done++;
        end
        done_prev = done;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic exp_rmw(input logic [9:0] a, input logic [7:0] m, input logic [7:0] v);
        int k;
        k = ridx(a);
        sh[k] = (sh[k] & ~m) | (v & m);
        exp_addr[exp_n] = a;
        exp_data[exp_n] = sh[k];
        exp_n++;
    endtask

    function automatic logic [7:0] en_mask(input int n);
        logic [7:0] m;
        m = 8'h44;
        if (n >= 2 && n <= 4) m = m | 8'h08;
        if (n >= 3 && n <= 4) m = m | 8'h10;
        if (n == 4) m = m | 8'h20;
        return m;
    endfunction

    task automatic exp_up(input int n);
        logic [7:0] m;
        m = en_mask(n);
        exp_rmw(10'h000, 8'h80, 8'h00);
        exp_rmw(10'h000, 8'h03, 8'h01);
        exp_rmw(10'h004, 8'h03, 8'h00);
        exp_rmw(10'h000, m, m);
        exp_rmw(10'h004, 8'h04, 8'h04);
        exp_rmw(10'h004, 8'h04, 8'h00);
        exp_rmw(10'h080, 8'h01, 8'h00);
        exp_rmw(10'h080, 8'h01, 8'h01);
    endtask

    task automatic exp_dn();
        exp_rmw(10'h000, 8'h7C, 8'h00);
        exp_rmw(10'h004, 8'h03, 8'h03);
        exp_rmw(10'h000, 8'h03, 8'h02);
        exp_rmw(10'h000, 8'h80, 8'h80);
        exp_rmw(10'h3AC, 8'h01, 8'h01);
    endtask

    task automatic prep(input logic [7:0] l, input logic [7:0] p,
                        input logic [7:0] dg, input logic [7:0] lv);
        mem[0] = l; mem[1] = p; mem[2] = dg; mem[3] = lv;
        for (int i = 0; i < 4; i++) sh[i] = mem[i];
        acc_n = 0; exp_n = 0; tn = 0; done_cnt = 0;
    endtask

    task automatic pulse(input bit up);
        @(negedge clk);
        if (up) pwr_up_req = 1'b1; else pwr_dn_req = 1'b1;
        @(negedge clk);
        pwr_up_req = 1'b0;
        pwr_dn_req = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int n;
        n = 0;
        while (done_cnt < target && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done_cnt >= target, "R10", "done reached", done_cnt, target);
    endtask

    task automatic cmp_log(input string req);
        check(acc_n == 2 * exp_n, req, "access count", acc_n, 2 * exp_n);
        for (int k = 0; k < exp_n && 2 * k + 1 < acc_n; k++) begin
            check(!acc_wr[2*k] && acc_addr[2*k] == exp_addr[k], "R4",
                  "read before write addr", int'(acc_addr[2*k]), int'(exp_addr[k]));
            check(acc_wr[2*k+1] && acc_addr[2*k+1] == exp_addr[k], req,
                  "write addr", int'(acc_addr[2*k+1]), int'(exp_addr[k]));
            check(acc_data[2*k+1] == exp_data[k], req,
                  "write data", int'(acc_data[2*k+1]), int'(exp_data[k]));
        end
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        check(!bus_rd && !bus_wr, "R1", "strobes after reset", int'({bus_rd, bus_wr}), 0);
        check(tim_start == 1'b0, "R1", "tim_start after reset", int'(tim_start), 0);
    endtask

    task automatic t_power_up(input int n);
        int ne;
        ne = (n >= 1 && n <= 4) ? n : 1;
        prep(8'h83, 8'hFB, 8'hA5, 8'h5A);
        lane_cnt = 3'(n);
        pulse(1'b1);
        check(busy == 1'b1, "R10", "busy during power-up", int'(busy), 1);
        wait_done(1);
        @(negedge clk);
        check(busy == 1'b0, "R10", "busy after power-up", int'(busy), 0);
        exp_up(ne);
        cmp_log("R2");
        check((mem[0] & 8'h7C) == en_mask(ne), "R3", "lane enables",
              int'(mem[0] & 8'h7C), int'(en_mask(ne)));
        check(tn == ne + 1, "R7", "timing handshakes", tn, ne + 1);
        for (int k = 0; k < ne && k < tn; k++)
            check(tim_log[k] == ne - 1 - k, "R7", "data lane order", tim_log[k], ne - 1 - k);
        if (tn == ne + 1)
            check(tim_log[ne] == 4, "R7", "clock lane last", tim_log[ne], 4);
        if (acc_n >= 16) begin
            check(acc_cyc[11] - acc_cyc[9] >= HOLD_CYC, "R6", "analog reset hold",
                  acc_cyc[11] - acc_cyc[9], HOLD_CYC);
            check(acc_cyc[15] - acc_cyc[13] >= HOLD_CYC, "R6", "digital reset hold",
                  acc_cyc[15] - acc_cyc[13], HOLD_CYC);
        end
        check(done_cyc - last_tim_cyc >= HOLD_CYC, "R8", "settle after timing",
              done_cyc - last_tim_cyc, HOLD_CYC);
        check(done_cnt == 1, "R10", "single done", done_cnt, 1);
    endtask

    task automatic t_power_down();
        prep(8'h7F, 8'hF8, 8'h01, 8'hA4);
        pulse(1'b0);
        check(busy == 1'b1, "R10", "busy during power-down", int'(busy), 1);
        wait_done(1);
        exp_dn();
        cmp_log("R9");
        check(tn == 0, "R9", "no timing in power-down", tn, 0);
    endtask

    task automatic t_off_during_up();
        prep(8'h00, 8'h03, 8'h00, 8'h00);
        lane_cnt = 3'd3;
        pulse(1'b1);
        repeat (30) @(negedge clk);
        pulse(1'b0);
        wait_done(1);
        check(acc_n == 16, "R11", "power-up finished before queued power-down", acc_n, 16);
        wait_done(2);
        exp_up(3);
        exp_dn();
        cmp_log("R11");
        check(done_cnt == 2, "R11", "two done pulses", done_cnt, 2);
    endtask

    task automatic t_on_during_down();
        prep(8'h7D, 8'h00, 8'h01, 8'h00);
        pulse(1'b0);
        repeat (3) @(negedge clk);
        pulse(1'b1);
        wait_done(1);
        repeat (300) @(negedge clk);
        check(acc_n == 10, "R11", "power-up during power-down ignored", acc_n, 10);
        check(busy == 1'b0 && tn == 0, "R11", "idle after ignored request", int'(busy), 0);
        check(done_cnt == 1, "R11", "done count", done_cnt, 1);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_power_up(4);
        t_power_down();
        t_power_up(2);
        t_power_up(3);
        t_power_up(1);
        t_power_up(0);
        t_power_up(7);
        t_off_during_up();
        t_on_during_down();
        check(bus_viol == 0, "R5", "bus strobe violations", bus_viol, 0);
        check(bad_addr == 0, "R2", "unknown addresses", bad_addr, 0);
        check(dup_done == 0, "R10", "done longer than one cycle", dup_done, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule